// File: doc/BRIEF.md
# Hall-Sensor Three-Phase Commutation Controller

This block drives a three-phase brushless motor bridge from three digitized Hall sensor bits. From each Hall state it picks one phase to source current (high side) and one phase to sink it (low side). It produces six enables, one per bridge transistor. Drive power is set by chopping only the active high-side enable with an internal PWM. The active low-side enable stays on for the whole commutation step.

Around the decode sit the control and protection paths:
- **Run/stop**: an input that starts and stops the motor.
- **Direction**: an input that is latched only while the motor is stopped.
- **Short brake**: an input that turns on every low side. Its release is honoured only while stopped.
- **Overcurrent**: a flag that cuts the high side at once and keeps it off for the rest of the PWM period.
- **Thermal fault**: a flag that turns every output off.

The Hall bits pass through a two-flop synchronizer before they are decoded.

Top module: `hall_commutator`

## Requirements
- R1: With direction forward, the synchronized Hall code {hall_in[2],hall_in[1],hall_in[0]} selects source/sink phases as: 101→V/U, 100→W/U, 110→W/V, 010→U/V, 011→U/W, 001→V/W. Phase bit 0 is U, bit 1 is V and bit 2 is W in both hi_en and lo_en. The high and low enables of one phase are never on together, and at most one high enable is on.
- R2: With direction reverse, the bitwise complement of the Hall code is decoded through the table of R1. For example, 010 gives source V and sink U.
- R3: Hall codes 000 and 111 turn all six enables off.
- R4: An 8-bit counter starts at 0 after reset and steps by one every clock, wrapping from 255 to 0. The selected high enable is on only while the counter is below `duty`, so a duty of 0 keeps the high side off. The selected low enable ignores the PWM.
- R5: While `oc_flag` is high the high side is off in the same cycle. After a clock edge that samples `oc_flag` high, the high side stays off until the edge at which the counter wraps from 255 to 0. The low side is not affected.
- R6: With `run` low and the brake released, all six enables are off.
- R7: With the brake engaged, all three low enables are on and all high enables are off. This applies whatever the values of `run`, the Hall code and the PWM. The brake engages at the first clock edge that samples `brake` high.
- R8: The brake is released only at a clock edge that samples `brake` low and `run` low together. Lowering `brake` while `run` is high leaves the brake engaged.
- R9: The direction input is captured only at clock edges that sample `run` low. Changes made while running have no effect until the next stop.
- R10: `ot_flag` high turns all six enables off in the same cycle, with priority over the brake.
- R11: A change on `hall_in` reaches the outputs after exactly two clock edges.
- R12: During and right after reset all enables are off, the direction is forward and the brake is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hall_in | input | 3 | Digitized Hall sensor bits (bit 2 = sensor 1) |
| duty | input | 8 | PWM on-duty word |
| run | input | 1 | 1 = run, 0 = stop |
| dir_rev | input | 1 | 1 = reverse, 0 = forward |
| brake | input | 1 | Short-brake request |
| oc_flag | input | 1 | Overcurrent flag |
| ot_flag | input | 1 | Thermal fault flag |
| hi_en | output | 3 | High-side source enables {W,V,U} |
| lo_en | output | 3 | Low-side sink enables {W,V,U} |

## Verification
The hardest situations to reach are the interlocks. A brake release or a direction change made while running must be shown to have no effect. An overcurrent blank must be shown to last across many counter values until the wrap.

Directed phases build these cases. One lowers `brake` while running and later stops. Another flips `dir_rev` while running and then watches the decode. Another pulses `oc_flag` mid-period with a large duty.

A long seeded random phase then mixes all the inputs. A behavioural model compares both enable vectors on every clock.

// File: rtl/hall_commutator.sv
module hall_commutator #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       hall_in,
  input  logic [CNT_W-1:0] duty,
  input  logic             run,
  input  logic             dir_rev,
  input  logic             brake,
  input  logic             oc_flag,
  input  logic             ot_flag,
  output logic [2:0]       hi_en,
  output logic [2:0]       lo_en
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [2:0] PH_U = 3'b001;
  localparam logic [2:0] PH_V = 3'b010;
  localparam logic [2:0] PH_W = 3'b100;

  logic [2:0]       hall_s1, hall_s2;
  logic             dir_q, brake_q, blank;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hall_s1 <= '0;
      hall_s2 <= '0;
      dir_q   <= 1'b0;
      brake_q <= 1'b0;
      cnt     <= '0;
      blank   <= 1'b0;
    end else begin
      hall_s1 <= hall_in;
      hall_s2 <= hall_s1;
      if (!run) dir_q <= dir_rev;
      if (brake) brake_q <= 1'b1;
      else if (!run) brake_q <= 1'b0;
      cnt <= cnt + 1'b1;
      if (oc_flag) blank <= 1'b1;
      else if (cnt == CNT_MAX) blank <= 1'b0;
    end
  end

  logic [2:0] code, src, snk;
  assign code = dir_q ? ~hall_s2 : hall_s2;

  always_comb begin
    unique case (code)
      3'b101:  begin src = PH_V; snk = PH_U; end
      3'b100:  begin src = PH_W; snk = PH_U; end
      3'b110:  begin src = PH_W; snk = PH_V; end
      3'b010:  begin src = PH_U; snk = PH_V; end
      3'b011:  begin src = PH_U; snk = PH_W; end
      3'b001:  begin src = PH_V; snk = PH_W; end
      default: begin src = 3'b000; snk = 3'b000; end
    endcase
  end

  logic hi_gate;
  assign hi_gate = (cnt < duty) && !oc_flag && !blank;

  always_comb begin
    hi_en = 3'b000;
    lo_en = 3'b000;
    if (ot_flag) begin
      hi_en = 3'b000;
      lo_en = 3'b000;
    end else if (brake_q) begin
      lo_en = 3'b111;
    end else if (run) begin
      hi_en = src & {3{hi_gate}};
      lo_en = snk;
    end
  end

  p_no_shoot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_en & lo_en) == 3'b000) && $onehot0(hi_en));
  p_duty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |-> (hi_en == 3'b000));
  p_oc_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag |-> (hi_en == 3'b000));
  p_oc_blank_r5: assert property (@(posedge clk) disable iff (!rst_n)
    oc_flag |=> (hi_en == 3'b000));
  p_stop_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !brake_q) |-> (hi_en == 3'b000 && lo_en == 3'b000));
  p_brake_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (brake && !ot_flag) |=> (lo_en == 3'b111 || ot_flag));
  p_brake_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (brake_q && run) |=> brake_q);
  p_dir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(dir_q));
  p_thermal_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ot_flag |-> (hi_en == 3'b000 && lo_en == 3'b000));
endmodule

// File: tb/test_hall_commutator.sv
module test_hall_commutator;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hall_in = 3'b000;
  logic [7:0] duty = 8'd255;
  logic run = 1'b0, dir_rev = 1'b0, brake = 1'b0, oc_flag = 1'b0, ot_flag = 1'b0;
  logic [2:0] hi_en, lo_en;

  hall_commutator i_hall_commutator (
    .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .duty(duty), .run(run),
    .dir_rev(dir_rev), .brake(brake), .oc_flag(oc_flag), .ot_flag(ot_flag),
    .hi_en(hi_en), .lo_en(lo_en));

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  string tag_ovr = "";

  int hq[$];
  int m_dir = 0, m_brk = 0, m_cnt = 0, m_blank = 0;

  initial begin
    hq.push_back(0);
    hq.push_back(0);
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      hq = {0, 0};
      m_dir = 0; m_brk = 0; m_cnt = 0; m_blank = 0;
    end else begin
      void'(hq.pop_front());
      hq.push_back(int'(hall_in));
      if (!run) m_dir = dir_rev;
      if (brake) m_brk = 1;
      else if (!run) m_brk = 0;
      if (oc_flag) m_blank = 1;
      else if (m_cnt == 255) m_blank = 0;
      m_cnt = (m_cnt + 1) % 256;
    end
  end

  task automatic expected(output logic [2:0] eh, output logic [2:0] el, output string tag);
    int c;
    logic [2:0] s, k;
    c = m_dir ? (7 - hq[0]) : hq[0];
    case (c)
      5: begin s = 3'b010; k = 3'b001; end
      4: begin s = 3'b100; k = 3'b001; end
      6: begin s = 3'b100; k = 3'b010; end
      2: begin s = 3'b001; k = 3'b010; end
      3: begin s = 3'b001; k = 3'b100; end
      1: begin s = 3'b010; k = 3'b100; end
      default: begin s = 3'b000; k = 3'b000; end
    endcase
    eh = 3'b000; el = 3'b000;
    if (!rst_n) tag = "R12";
    else if (ot_flag) tag = "R10";
    else if (m_brk != 0) begin el = 3'b111; tag = "R7"; end
    else if (!run) tag = "R6";
    else if (s == 3'b000) tag = "R3";
    else begin
      el = k;
      if (oc_flag || m_blank != 0) tag = "R5";
      else if (m_cnt >= int'(duty)) tag = "R4";
      else begin eh = s; tag = m_dir ? "R2" : "R1"; end
    end
    if (tag_ovr != "") tag = tag_ovr;
  endtask

  task automatic tick();
    logic [2:0] eh, el;
    string tag;
    @(posedge clk);
    #(PERIOD/4);
    expected(eh, el, tag);
    checks++;
    if (hi_en !== eh || lo_en !== el) begin
      fails++;
      $display("FAIL %s t=%0t hi_en=%b lo_en=%b expected hi_en=%b lo_en=%b",
               tag, $time, hi_en, lo_en, eh, el);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog R1..: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [2:0] seq[8] = '{3'b101, 3'b100, 3'b110, 3'b010, 3'b011, 3'b001, 3'b000, 3'b111};
    // R12: reset state
    tag_ovr = "R12";
    ticks(3);
    rst_n = 1'b1;
    tick();
    tag_ovr = "";
    // R1 forward sweep, R11 latency on each change, R3 illegal codes
    run = 1'b1;
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < 8; i++) begin
        hall_in = seq[i];
        tag_ovr = "R11";
        ticks(2);
        tag_ovr = "";
        ticks(4);
      end
      // R9/R2: stop, select reverse, restart
      run = 1'b0;
      dir_rev = 1'b1;
      ticks(2);
      run = 1'b1;
    end
    // R9: direction change while running is ignored
    dir_rev = 1'b0;
    hall_in = 3'b010;
    tag_ovr = "R9";
    ticks(6);
    tag_ovr = "";
    // R4: duty patterns over full periods
    duty = 8'd64;  ticks(520);
    duty = 8'd0;   ticks(260);
    duty = 8'd200; ticks(100);
    // R5: overcurrent pulse mid-period then blanking until wrap
    oc_flag = 1'b1; tick();
    oc_flag = 1'b0; ticks(300);
    // R7 brake while running, R8 release while running ignored
    brake = 1'b1; ticks(3);
    brake = 1'b0;
    tag_ovr = "R8";
    ticks(5);
    tag_ovr = "";
    run = 1'b0; ticks(3);
    // R7 brake while stopped, R10 thermal over brake and over drive
    brake = 1'b1; ticks(3);
    ot_flag = 1'b1; ticks(3);
    ot_flag = 1'b0; brake = 1'b0; ticks(2);
    run = 1'b1; ticks(3);
    ot_flag = 1'b1; ticks(3);
    ot_flag = 1'b0; ticks(3);
    // mixed random stimulus
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(3) == 0) hall_in = 3'($urandom_range(7));
      if ($urandom_range(60) == 0) run = ~run;
      if ($urandom_range(80) == 0) dir_rev = ~dir_rev;
      if ($urandom_range(150) == 0) brake = ~brake;
      oc_flag = ($urandom_range(90) == 0);
      ot_flag = ($urandom_range(200) == 0);
      if ($urandom_range(300) == 0) duty = 8'($urandom_range(255));
      tick();
    end
    finish_run();
  end
endmodule